// File: doc/BRIEF.md
# Timed Fault Campaign Sequencer with Saboteur Cells

This block sits next to a design under test and runs a fault campaign in hardware. Through a small write port, a host fills a table with one entry per fault site. Each entry holds an activation delay, a propagation window, a corruption kind and a persistence bit. A start pulse then makes the block walk the table from entry 0 up to a chosen last entry. For each entry, one counter waits out the delay. A second counter then waits out the window, and during that window the entry's fault is in force.

The block drives one active-high injection line per fault site, and at most one of them is high at a time. It also reports the index of the entry being processed, and pulses a capture strobe at the end of every window so that a result capture unit can sample the design under test. A bank of saboteur cells, one per site, passes a site wire through unchanged while its injection line is low. While the line is high, the cell forces the wire to 0, forces it to 1, or inverts it, according to the active entry's kind. A permanent fault holds its injection line high for the whole window. A transient fault pulses it for a single cycle.

Top module: `fault_campaign_mgr`

## Requirements
- R1: During and right after a synchronous reset, busy, done, fault_active, capture_stb and every injection line are low.
- R2: An entry's first injection cycle begins D+1 rising edges after one of two edges, where D is the entry's delay field: for entry 0, the edge that samples start; for later entries, the edge that ends the previous entry's window.
- R3: An entry's window lasts W+1 cycles, where W is its window field. capture_stb is high in exactly the last cycle of each window, and fault_active is low in the cycle after it.
- R4: For a permanent entry (persistence bit 1), the entry's injection line is high in every cycle of its window.
- R5: For a transient entry (persistence bit 0), the entry's injection line is high only in the first cycle of its window.
- R6: At most one injection line is high at a time, and all of them are low whenever fault_active is low.
- R7: While injection line i is high, active_idx equals i, and fault_active is high.
- R8: Entries run in ascending order from 0 to last_idx, with last_idx sampled at start and clamped to the final table entry. done rises one cycle after the last window's capture strobe and stays high, with busy low, until the next start.
- R9: A saboteur cell passes site_in to site_out while its injection line is low. While the line is high it applies the active entry's kind field: 0 drives 0, 1 drives 1, 2 inverts the input, and 3 passes the input through.
- R10: Table writes made while busy is high are ignored.
- R11: A start pulse while busy is high is ignored, and the campaign in progress keeps its timing.
- R12: A reset in the middle of a campaign returns the block to idle, with every injection line low and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_delay | input | CNT_W | Activation delay field |
| cfg_window | input | CNT_W | Propagation window field |
| cfg_kind | input | 2 | Corruption kind: 0 stuck-at-0, 1 stuck-at-1, 2 invert, 3 pass |
| cfg_perm | input | 1 | 1 permanent, 0 transient |
| start | input | 1 | Begins a campaign at entry 0 |
| last_idx | input | IDX_W | Last entry of the campaign |
| fis | output | N_FAULTS | One-hot injection lines, one per site |
| active_idx | output | IDX_W | Index of the entry in progress |
| fault_active | output | 1 | High during a propagation window |
| capture_stb | output | 1 | Pulse in the last cycle of each window |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | Campaign finished |
| site_in | input | N_FAULTS | Fault-free site wires |
| site_out | output | N_FAULTS | Site wires after the saboteurs |

## Verification
The bench builds the block with N_FAULTS=4 and CNT_W=8. With four entries, a single campaign can mix every corruption kind, including the reserved pass-through code 3, and can cover both permanent and transient entries. With 8-bit counters, the delays and windows stay short enough to count out edge by edge: zero delay, zero-length windows, back-to-back entries, and a partial campaign that stops at a last_idx below the final entry. The same four sites make it possible to write a non-running entry during a campaign and show, on a later run, that the write had no effect.

// File: rtl/fi_pkg.sv
package fi_pkg;

    typedef enum logic [1:0] {
        FK_ZERO = 2'd0,
        FK_ONE  = 2'd1,
        FK_INV  = 2'd2,
        FK_PASS = 2'd3
    } fault_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_HOLD = 2'd2,
        SQ_FIN  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/fi_fault_table.sv
module fi_fault_table
    import fi_pkg::*;
#(
    parameter int N_FAULTS = 4,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = (N_FAULTS > 1) ? $clog2(N_FAULTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_delay,
    input  logic [CNT_W-1:0] wr_window,
    input  logic [1:0]       wr_kind,
    input  logic             wr_perm,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_delay,
    output logic [CNT_W-1:0] rd_window,
    output fault_kind_e      rd_kind,
    output logic             rd_perm
);

    logic [CNT_W-1:0] delay_d  [N_FAULTS];
    logic [CNT_W-1:0] delay_q  [N_FAULTS];
    logic [CNT_W-1:0] window_d [N_FAULTS];
    logic [CNT_W-1:0] window_q [N_FAULTS];
    fault_kind_e      kind_d   [N_FAULTS];
    fault_kind_e      kind_q   [N_FAULTS];
    logic             perm_d   [N_FAULTS];
    logic             perm_q   [N_FAULTS];

    logic accept;
    assign accept = wr_en && !busy;

    always_comb begin
        for (int i = 0; i < N_FAULTS; i++) begin
            delay_d[i]  = delay_q[i];
            window_d[i] = window_q[i];
            kind_d[i]   = kind_q[i];
            perm_d[i]   = perm_q[i];
            if (accept && (wr_idx == IDX_W'(i))) begin
                delay_d[i]  = wr_delay;
                window_d[i] = wr_window;
                kind_d[i]   = fault_kind_e'(wr_kind);
                perm_d[i]   = wr_perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_FAULTS; i++) begin
            if (rst) begin
                delay_q[i]  <= '0;
                window_q[i] <= '0;
                kind_q[i]   <= FK_PASS;
                perm_q[i]   <= 1'b0;
            end else begin
                delay_q[i]  <= delay_d[i];
                window_q[i] <= window_d[i];
                kind_q[i]   <= kind_d[i];
                perm_q[i]   <= perm_d[i];
            end
        end
    end

    assign rd_delay  = delay_q[rd_idx];
    assign rd_window = window_q[rd_idx];
    assign rd_kind   = kind_q[rd_idx];
    assign rd_perm   = perm_q[rd_idx];

    generate
        for (genvar g = 0; g < N_FAULTS; g++) begin : g_hold_chk
            // R10
            locked_entry_chk: assert property (@(posedge clk) disable iff (rst)
                busy |=> ($stable(delay_q[g]) && $stable(window_q[g]) && $stable(perm_q[g])));
        end
    endgenerate

endmodule

// File: rtl/fi_sequencer.sv
module fi_sequencer
    import fi_pkg::*;
#(
    parameter int N_FAULTS = 4,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = (N_FAULTS > 1) ? $clog2(N_FAULTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [IDX_W-1:0]    last_idx,
    input  logic [CNT_W-1:0]    ent_delay,
    input  logic [CNT_W-1:0]    ent_window,
    input  logic                ent_perm,
    output logic [IDX_W-1:0]    cur_idx,
    output logic [N_FAULTS-1:0] fis,
    output logic                fault_active,
    output logic                capture_stb,
    output logic                busy,
    output logic                done
);

    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_FAULTS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic inject;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE, SQ_FIN: begin
                if (start) begin
                    s_d.st   = SQ_WAIT;
                    s_d.idx  = '0;
                    s_d.cnt  = '0;
                    s_d.last = (last_idx > MAX_IDX) ? MAX_IDX : last_idx;
                end
            end
            SQ_WAIT: begin
                if (s_q.cnt == ent_delay) begin
                    s_d.st  = SQ_HOLD;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_HOLD: begin
                if (s_q.cnt == ent_window) begin
                    s_d.cnt = '0;
                    if (s_q.idx == s_q.last) begin
                        s_d.st = SQ_FIN;
                    end else begin
                        s_d.st  = SQ_WAIT;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st   <= SQ_IDLE;
            s_q.idx  <= '0;
            s_q.last <= '0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fault_active = (s_q.st == SQ_HOLD);
    assign busy         = (s_q.st == SQ_WAIT) || fault_active;
    assign done         = (s_q.st == SQ_FIN);
    assign capture_stb  = fault_active && (s_q.cnt == ent_window);
    assign inject       = fault_active && (ent_perm || (s_q.cnt == '0));
    assign cur_idx      = s_q.idx;

    generate
        for (genvar g = 0; g < N_FAULTS; g++) begin : g_line
            assign fis[g] = inject && (s_q.idx == IDX_W'(g));
        end
    endgenerate

    // R6
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fis) && (!fault_active -> (fis == '0)));
    // R5
    transient_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ((fis != '0) && !ent_perm) |=> (fis == '0));
    // R3
    window_end_chk: assert property (@(posedge clk) disable iff (rst)
        capture_stb |=> !fault_active);
    // R8
    finished_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && (fis == '0)));
    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !capture_stb) |=> (busy && $stable(cur_idx)));
    // R12
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && (fis == '0)));

endmodule

// File: rtl/fi_saboteur.sv
module fi_saboteur
    import fi_pkg::*;
(
    input  logic        inj,
    input  fault_kind_e kind,
    input  logic        din,
    output logic        dout
);

    always_comb begin
        dout = din;
        if (inj) begin
            unique case (kind)
                FK_ZERO: dout = 1'b0;
                FK_ONE:  dout = 1'b1;
                FK_INV:  dout = ~din;
                default: dout = din;
            endcase
        end
    end

endmodule

// File: rtl/fault_campaign_mgr.sv
module fault_campaign_mgr
    import fi_pkg::*;
#(
    parameter int N_FAULTS = 4,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = (N_FAULTS > 1) ? $clog2(N_FAULTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [CNT_W-1:0]    cfg_delay,
    input  logic [CNT_W-1:0]    cfg_window,
    input  logic [1:0]          cfg_kind,
    input  logic                cfg_perm,
    input  logic                start,
    input  logic [IDX_W-1:0]    last_idx,
    output logic [N_FAULTS-1:0] fis,
    output logic [IDX_W-1:0]    active_idx,
    output logic                fault_active,
    output logic                capture_stb,
    output logic                busy,
    output logic                done,
    input  logic [N_FAULTS-1:0] site_in,
    output logic [N_FAULTS-1:0] site_out
);

    logic [CNT_W-1:0] ent_delay;
    logic [CNT_W-1:0] ent_window;
    fault_kind_e      ent_kind;
    logic             ent_perm;

    fi_fault_table #(.N_FAULTS(N_FAULTS), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_delay  (cfg_delay),
        .wr_window (cfg_window),
        .wr_kind   (cfg_kind),
        .wr_perm   (cfg_perm),
        .rd_idx    (active_idx),
        .rd_delay  (ent_delay),
        .rd_window (ent_window),
        .rd_kind   (ent_kind),
        .rd_perm   (ent_perm)
    );

    fi_sequencer #(.N_FAULTS(N_FAULTS), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .last_idx     (last_idx),
        .ent_delay    (ent_delay),
        .ent_window   (ent_window),
        .ent_perm     (ent_perm),
        .cur_idx      (active_idx),
        .fis          (fis),
        .fault_active (fault_active),
        .capture_stb  (capture_stb),
        .busy         (busy),
        .done         (done)
    );

    generate
        for (genvar g = 0; g < N_FAULTS; g++) begin : g_site
            fi_saboteur u_sab (
                .inj  (fis[g]),
                .kind (ent_kind),
                .din  (site_in[g]),
                .dout (site_out[g])
            );
            // R9
            clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
                !fis[g] |-> (site_out[g] == site_in[g]));
            // R7
            line_idx_chk: assert property (@(posedge clk) disable iff (rst)
                fis[g] |-> (fault_active && (active_idx == IDX_W'(g))));
        end
    endgenerate

endmodule

// File: tb/tb_fault_campaign_mgr.sv
module tb_fault_campaign_mgr;

    localparam int N  = 4;
    localparam int CW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [CW-1:0] cfg_delay = '0;
    logic [CW-1:0] cfg_window = '0;
    logic [1:0]    cfg_kind = '0;
    logic          cfg_perm = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] last_idx = '0;
    logic [N-1:0]  fis;
    logic [IW-1:0] active_idx;
    logic          fault_active, capture_stb, busy, done;
    logic [N-1:0]  site_in = '0;
    logic [N-1:0]  site_out;

    fault_campaign_mgr #(.N_FAULTS(N), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_delay(cfg_delay), .cfg_window(cfg_window), .cfg_kind(cfg_kind),
        .cfg_perm(cfg_perm), .start(start), .last_idx(last_idx), .fis(fis),
        .active_idx(active_idx), .fault_active(fault_active),
        .capture_stb(capture_stb), .busy(busy), .done(done),
        .site_in(site_in), .site_out(site_out)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        site_in <= 4'(cyc * 7 + 3);
    end

    int checks = 0, fails = 0;
    int m_dly[N], m_win[N], m_kind[N], m_perm[N];
    int rise_cyc[N], hi_cnt[N], stb_cyc[N];
    int done_cyc, sab_err, oh_err, idx_err;
    logic [N-1:0] fis_prev = '0;
    logic done_prev = 1'b0;

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            logic e;
            e = site_in[i];
            if (fis[i]) begin
                hi_cnt[i]++;
                if (!fis_prev[i] && rise_cyc[i] < 0) rise_cyc[i] = cyc;
                if (active_idx != IW'(i) || !fault_active) idx_err++;
                case (m_kind[i])
                    0: e = 1'b0;
                    1: e = 1'b1;
                    2: e = ~site_in[i];
                    default: e = site_in[i];
                endcase
            end
            if (site_out[i] !== e) sab_err++;
        end
        if ($countones(fis) > 1) oh_err++;
        if (fis != '0 && !fault_active) oh_err++;
        if (capture_stb) stb_cyc[active_idx] = cyc;
        if (done && !done_prev) done_cyc = cyc;
        fis_prev = fis;
        done_prev = done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic clear_rec();
        for (int i = 0; i < N; i++) begin
            rise_cyc[i] = -1; hi_cnt[i] = 0; stb_cyc[i] = -1;
        end
        done_cyc = -1; sab_err = 0; oh_err = 0; idx_err = 0;
    endtask

    task automatic load(input int i, input int d, input int w, input int k, input int p, input bit model);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(i); cfg_delay = CW'(d);
        cfg_window = CW'(w); cfg_kind = 2'(k); cfg_perm = p[0];
        if (model) begin
            m_dly[i] = d; m_win[i] = w; m_kind[i] = k; m_perm[i] = p;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs a campaign and checks R2 R3 R4 R5 R6 R7 R8 R9; disturb covers R10 R11
    task automatic run_campaign(input int last, input bit disturb);
        int s, t, exp_done;
        int rise_e[N], stb_e[N];
        clear_rec();
        @(negedge clk);
        last_idx = IW'(last);
        start = 1'b1;
        s = cyc;
        t = s;
        for (int i = 0; i <= last; i++) begin
            rise_e[i] = t + m_dly[i] + 2;
            stb_e[i]  = rise_e[i] + m_win[i];
            t = stb_e[i];
        end
        exp_done = t + 1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (2) @(negedge clk);
            chk(busy == 1'b1, "R11 busy before stray start", int'(busy), 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            load(2, 20, 9, 0, 0, 1'b0);
        end
        while (cyc < exp_done + 2) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (i <= last) begin
                chk(rise_cyc[i] == rise_e[i], $sformatf("R2 entry %0d rise", i), rise_cyc[i], rise_e[i]);
                chk(stb_cyc[i] == stb_e[i], $sformatf("R3 entry %0d strobe", i), stb_cyc[i], stb_e[i]);
                if (m_perm[i] != 0)
                    chk(hi_cnt[i] == m_win[i] + 1, $sformatf("R4 entry %0d high cycles", i), hi_cnt[i], m_win[i] + 1);
                else
                    chk(hi_cnt[i] == 1, $sformatf("R5 entry %0d high cycles", i), hi_cnt[i], 1);
            end else begin
                chk(hi_cnt[i] == 0, $sformatf("R8 entry %0d beyond last", i), hi_cnt[i], 0);
            end
        end
        chk(done_cyc == exp_done, "R8 done timing", done_cyc, exp_done);
        chk(done && !busy, "R8 done held busy low", int'({done, busy}), 2);
        chk(oh_err == 0, "R6 one-hot and idle lines", oh_err, 0);
        chk(idx_err == 0, "R7 active index", idx_err, 0);
        chk(sab_err == 0, "R9 saboteur output", sab_err, 0);
    endtask

    task automatic t_reset_state();
        repeat (2) @(negedge clk);
        chk(!busy && !done && !fault_active && !capture_stb, "R1 status at reset",
            int'({busy, done, fault_active, capture_stb}), 0);
        chk(fis == '0, "R1 lines at reset", int'(fis), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && fis == '0, "R1 idle after reset", int'({busy, done}), 0);
    endtask

    task automatic t_mixed_campaign();
        load(0, 2, 2, 0, 1, 1'b1);
        load(1, 0, 0, 1, 0, 1'b1);
        load(2, 3, 4, 2, 1, 1'b1);
        load(3, 1, 1, 3, 0, 1'b1);
        run_campaign(3, 1'b0);
    endtask

    task automatic t_partial_disturbed();
        load(0, 4, 1, 1, 0, 1'b1);
        load(1, 0, 3, 2, 1, 1'b1);
        run_campaign(1, 1'b1);
        // R10: entry 2 must still hold its earlier fields
        run_campaign(2, 1'b0);
    endtask

    task automatic t_mid_reset();
        int guard = 0;
        @(negedge clk);
        last_idx = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fault_active && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(fault_active == 1'b1, "R12 window reached", int'(fault_active), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && fis == '0 && !fault_active, "R12 idle after reset",
            int'({busy, done, fault_active}), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && fis == '0, "R12 stays idle", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_dly[i] = 0; m_win[i] = 0; m_kind[i] = 3; m_perm[i] = 0;
        end
        clear_rec();
        t_reset_state();
        t_mixed_campaign();
        t_partial_disturbed();
        t_mid_reset();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        summary();
        $finish;
    end

endmodule